// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox Pair

This block joins a host CPU register bus to a coprocessor through two 32-bit mailboxes, one for each direction. Each mailbox holds 31 payload bits and a handshake flag. The flag is the most significant bit of the mailbox's high halfword. The host sees each mailbox as two 16-bit registers, and it may access them one half at a time or as a single 32-bit word.

The inbound mailbox belongs to the host. The host fills it and raises its flag. The coprocessor takes the payload and pulses an accept strobe, which drops the flag. The outbound mailbox belongs to the coprocessor. A coprocessor write strobe loads the payload and raises the flag. The host sees that mailbox as read-only, and reading its low half retires the message.

The host bus carries halfwords in big-endian lanes. The halfword at an even-pair offset (0x0 or 0x4) travels on bits 31:16, and the halfword at offset +2 travels on bits 15:0. Read data is registered.

Top module: `cpu_dsp_mbox`

## Requirements
- R1: After a synchronous reset, both mailboxes hold zero: `cop_in_valid` and `cop_out_full` are 0, and host reads of any register return 0.
- R2: A halfword host write (`host_size32`=0) to offset 0x0 takes bits 31:16 of `host_wdata` as the inbound high half. A halfword write to offset 0x2 takes bits 15:0 as the inbound low half. A halfword read of the same offset returns that value in the same lane, with the other lane 0.
- R3: A 32-bit host access at offset 0x0 or 0x4 covers both halves of that mailbox. The high half is on bits 31:16 and the low half is on bits 15:0.
- R4: `cop_in_valid` equals bit 15 of the inbound high half. `cop_in_data` equals inbound high bits 14:0 followed by the inbound low half.
- R5: A pulse on `cop_in_ack` clears the inbound flag one cycle later and leaves all 31 payload bits unchanged. An accept while the flag is 0 changes nothing.
- R6: When a host write to the inbound high half coincides with `cop_in_ack`, the flag takes bit 31 of the written data.
- R7: A pulse on `cop_out_wr` loads `cop_out_data` into the outbound mailbox and sets its flag. The host then reads offset 0x4 as {1, data[30:16]} and offset 0x6 as data[15:0].
- R8: Host writes to offsets 0x4 and 0x6 do not change the outbound mailbox or `cop_out_full`.
- R9: A host read that covers the outbound low half, whether a halfword read at 0x6 or a 32-bit read at 0x4, clears the outbound flag. The read returns the flag as it stood before the clear, and the payload is kept. A halfword read of 0x4 alone leaves the flag set.
- R10: When `cop_out_wr` coincides with a clearing host read, the read returns the old contents, the flag stays 1, and the new payload is stored.
- R11: `host_rdata` updates on the clock edge after the cycle in which `host_rd` is high, and holds its value until the next read.
- R12: An access with address bit 0 set, or with any address bit above bit 2 set, is ignored: it writes nothing, clears nothing, and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| host_wdata | input | 2*HALF_W | Host write data, big-endian halfword lanes |
| host_rdata | output | 2*HALF_W | Registered host read data |
| cop_in_data | output | 2*HALF_W-1 | Inbound payload to the coprocessor |
| cop_in_valid | output | 1 | Inbound flag |
| cop_in_ack | input | 1 | Coprocessor accept strobe |
| cop_out_wr | input | 1 | Coprocessor write strobe for the outbound mailbox |
| cop_out_data | input | 2*HALF_W-1 | Outbound payload from the coprocessor |
| cop_out_full | output | 1 | Outbound flag |

## Verification
The bench targets these corner cases:

- **Host write racing an accept.** A design that gave the accept priority would drop a freshly posted flag, and the coprocessor would never see the message.
- **Coprocessor write racing the retiring read.** A design that let the read win would lose the flag on a new message.
- **Reads of the outbound high half alone.** A design that decoded loosely would clear the flag on those reads, and a waiting message would vanish.
- **Writes aimed at the outbound mailbox, and misaligned or out-of-window addresses.** The bench checks these at the ports. A design that leaked such writes would show corrupted contents on read-back.
- **Lane placement.** Swapped halves would show up directly in the values read back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Address bit that selects the mailbox pair (0 = inbound, 1 = outbound)
  localparam int PAIR_BIT = 2;
  // Address bit that selects the low halfword within a pair
  localparam int LANE_BIT = 1;

  typedef struct packed {
    logic hit;       // aligned and inside the window
    logic hi_lane;   // access touches the high half
    logic lo_lane;   // access touches the low half
    logic out_pair;  // access targets the outbound mailbox
  } mbox_access_t;
endpackage

// File: rtl/mbox_host_decode.sv
module mbox_host_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              size32,
  output mbox_access_t      acc,
  output logic              in_hi_we,
  output logic              in_lo_we,
  output logic              out_lo_rd
);
  logic upper_zero;

  generate
    if (ADDR_W > 3) begin : g_upper
      assign upper_zero = ~|addr[ADDR_W-1:3];
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    acc.hit      = upper_zero & ~addr[0];
    acc.out_pair = addr[PAIR_BIT];
    acc.hi_lane  = acc.hit & (size32 | ~addr[LANE_BIT]);
    acc.lo_lane  = acc.hit & (size32 |  addr[LANE_BIT]);
  end

  assign in_hi_we  = wr & acc.hi_lane & ~acc.out_pair;
  assign in_lo_we  = wr & acc.lo_lane & ~acc.out_pair;
  assign out_lo_rd = rd & acc.lo_lane &  acc.out_pair;
endmodule

// File: rtl/mbox_inbound.sv
module mbox_inbound #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [HALF_W-1:0] wdata_hi,
  input  logic [HALF_W-1:0] wdata_lo,
  input  logic              ack,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (we_lo) lo_q <= wdata_lo;
      // host write to the high half outranks the accept strobe
      if (we_hi)    hi_q <= wdata_hi;
      else if (ack) hi_q[HALF_W-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound #(
  parameter int HALF_W = 16,
  localparam int PAY_W = 2*HALF_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cop_wr,
  input  logic [PAY_W-1:0]  cop_data,
  input  logic              clr,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cop_wr) begin
      // a new message outranks retirement of the old one
      {hi_q, lo_q} <= {1'b1, cop_data};
    end else if (clr) begin
      hi_q[HALF_W-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_read_port.sv
module mbox_read_port
  import mbox_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2*HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  mbox_access_t      acc,
  input  logic [HALF_W-1:0] in_hi,
  input  logic [HALF_W-1:0] in_lo,
  input  logic [HALF_W-1:0] out_hi,
  input  logic [HALF_W-1:0] out_lo,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] rd_next;

  // lane 1 carries the high half (bits 31:16), lane 0 the low half
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic              touch;
      logic [HALF_W-1:0] src;
      if (g == 1) begin : g_hi
        assign touch = acc.hi_lane;
        assign src   = acc.out_pair ? out_hi : in_hi;
      end else begin : g_lo
        assign touch = acc.lo_lane;
        assign src   = acc.out_pair ? out_lo : in_lo;
      end
      assign rd_next[g*HALF_W +: HALF_W] = touch ? src : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/cpu_dsp_mbox.sv
module cpu_dsp_mbox
  import mbox_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 4,
  localparam int WORD_W = 2*HALF_W,
  localparam int PAY_W  = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_size32,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic [PAY_W-1:0]  cop_in_data,
  output logic              cop_in_valid,
  input  logic              cop_in_ack,
  input  logic              cop_out_wr,
  input  logic [PAY_W-1:0]  cop_out_data,
  output logic              cop_out_full
);
  mbox_access_t      acc;
  logic              in_hi_we, in_lo_we, out_lo_rd;
  logic [HALF_W-1:0] in_hi, in_lo, out_hi, out_lo;

  mbox_host_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (host_addr),
    .wr        (host_wr),
    .rd        (host_rd),
    .size32    (host_size32),
    .acc       (acc),
    .in_hi_we  (in_hi_we),
    .in_lo_we  (in_lo_we),
    .out_lo_rd (out_lo_rd)
  );

  mbox_inbound #(.HALF_W(HALF_W)) u_in (
    .clk      (clk),
    .rst      (rst),
    .we_hi    (in_hi_we),
    .we_lo    (in_lo_we),
    .wdata_hi (host_wdata[WORD_W-1:HALF_W]),
    .wdata_lo (host_wdata[HALF_W-1:0]),
    .ack      (cop_in_ack),
    .hi_q     (in_hi),
    .lo_q     (in_lo)
  );

  mbox_outbound #(.HALF_W(HALF_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .cop_wr   (cop_out_wr),
    .cop_data (cop_out_data),
    .clr      (out_lo_rd),
    .hi_q     (out_hi),
    .lo_q     (out_lo)
  );

  mbox_read_port #(.HALF_W(HALF_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (host_rd),
    .acc    (acc),
    .in_hi  (in_hi),
    .in_lo  (in_lo),
    .out_hi (out_hi),
    .out_lo (out_lo),
    .rdata  (host_rdata)
  );

  assign cop_in_valid = in_hi[HALF_W-1];
  assign cop_in_data  = {in_hi[HALF_W-2:0], in_lo};
  assign cop_out_full = out_hi[HALF_W-1];
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int ADDR_W = 4,
  parameter int PAY_W  = 31
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_size32,
  input logic              set_bit,
  input logic              cop_in_valid,
  input logic              cop_in_ack,
  input logic [PAY_W-1:0]  cop_in_data,
  input logic              cop_out_wr,
  input logic              cop_out_full
);
  logic win, hi_t, lo_t, in_hi_wr, in_any_wr, out_lo_rd;

  assign win       = ((host_addr >> 3) == '0) && !host_addr[0];
  assign hi_t      = win && (host_size32 || !host_addr[1]);
  assign lo_t      = win && (host_size32 ||  host_addr[1]);
  assign in_hi_wr  = host_wr && hi_t && !host_addr[2];
  assign in_any_wr = host_wr && (hi_t || lo_t) && !host_addr[2];
  assign out_lo_rd = host_rd && lo_t && host_addr[2];

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (!cop_in_valid && !cop_out_full)); // R1

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cop_in_ack && !in_hi_wr) |=> !cop_in_valid); // R5

  AST_IN_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (rst)
    !in_any_wr |=> $stable(cop_in_data)); // R5

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
    in_hi_wr |=> (cop_in_valid == $past(set_bit))); // R6

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cop_out_wr |=> cop_out_full); // R7

  AST_OUT_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (out_lo_rd && !cop_out_wr) |=> !cop_out_full); // R9

  AST_OUT_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cop_out_wr && !out_lo_rd) |=> $stable(cop_out_full)); // R8
endmodule

bind cpu_dsp_mbox mbox_checker #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_addr    (host_addr),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_size32  (host_size32),
  .set_bit      (host_wdata[WORD_W-1]),
  .cop_in_valid (cop_in_valid),
  .cop_in_ack   (cop_in_ack),
  .cop_in_data  (cop_in_data),
  .cop_out_wr   (cop_out_wr),
  .cop_out_full (cop_out_full)
);

// File: tb/cpu_dsp_mbox_test.sv
module cpu_dsp_mbox_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  host_addr;
  logic        host_wr, host_rd, host_size32;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [30:0] cop_in_data;
  logic        cop_in_valid;
  logic        cop_in_ack;
  logic        cop_out_wr;
  logic [30:0] cop_out_data;
  logic        cop_out_full;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  cpu_dsp_mbox uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_size32(host_size32), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cop_in_data(cop_in_data),
    .cop_in_valid(cop_in_valid), .cop_in_ack(cop_in_ack),
    .cop_out_wr(cop_out_wr), .cop_out_data(cop_out_data),
    .cop_out_full(cop_out_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; host_size32 = 0; host_addr = 0; host_wdata = 0;
    cop_in_ack = 0; cop_out_wr = 0; cop_out_data = 0;
  endtask

  task automatic hwrite(input logic [3:0] a, input logic s32, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_size32 = s32; host_wdata = d; host_wr = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic hread(input logic [3:0] a, input logic s32, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_size32 = s32; host_rd = 1;
    @(negedge clk);
    d = host_rdata;
    idle();
  endtask

  task automatic cwrite(input logic [30:0] d);
    @(negedge clk);
    cop_out_wr = 1; cop_out_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    check("R1 in flag", {31'd0, cop_in_valid}, 32'd0);
    check("R1 out flag", {31'd0, cop_out_full}, 32'd0);
    hread(4'h0, 1, rv); check("R1 inbound word", rv, 32'd0);
    hread(4'h4, 1, rv); check("R1 outbound word", rv, 32'd0);
  endtask

  task automatic t_halves();
    hwrite(4'h0, 0, 32'h8ABC_0000);
    hwrite(4'h2, 0, 32'h0000_1234);
    hread(4'h0, 0, rv); check("R2 high half", rv, 32'h8ABC_0000);
    hread(4'h2, 0, rv); check("R2 low half", rv, 32'h0000_1234);
    check("R4 in data", {1'b0, cop_in_data}, {1'b0, 15'h0ABC, 16'h1234});
    check("R4 in valid", {31'd0, cop_in_valid}, 32'd1);
    // R11: rdata holds between reads
    repeat (3) @(negedge clk);
    check("R11 rdata held", host_rdata, 32'h0000_1234);
  endtask

  task automatic t_word();
    hwrite(4'h0, 1, 32'h7FFF_5555);
    hread(4'h0, 1, rv); check("R3 word readback", rv, 32'h7FFF_5555);
    check("R3 flag from word", {31'd0, cop_in_valid}, 32'd0);
  endtask

  task automatic t_accept();
    hwrite(4'h0, 1, 32'h8001_0002);
    @(negedge clk); cop_in_ack = 1;
    @(negedge clk); idle();
    check("R5 flag cleared", {31'd0, cop_in_valid}, 32'd0);
    check("R5 payload kept", {1'b0, cop_in_data}, {1'b0, 15'h0001, 16'h0002});
    @(negedge clk); cop_in_ack = 1;
    @(negedge clk); idle();
    hread(4'h0, 1, rv); check("R5 idle accept", rv, 32'h0001_0002);
  endtask

  task automatic t_race_in();
    hwrite(4'h0, 0, 32'h8000_0000);
    @(negedge clk);
    cop_in_ack = 1; host_wr = 1; host_addr = 4'h0; host_size32 = 0;
    host_wdata = 32'h8123_0000;
    @(negedge clk); idle();
    check("R6 host wins flag", {31'd0, cop_in_valid}, 32'd1);
    hread(4'h0, 0, rv); check("R6 host wins data", rv, 32'h8123_0000);
  endtask

  task automatic t_outbound();
    cwrite(31'h1234_5678);
    check("R7 full", {31'd0, cop_out_full}, 32'd1);
    hread(4'h4, 0, rv); check("R7 out high", rv, 32'h9234_0000);
    check("R9 high read keeps flag", {31'd0, cop_out_full}, 32'd1);
    hwrite(4'h4, 1, 32'hFFFF_FFFF);
    hwrite(4'h6, 0, 32'h0000_0000);
    check("R8 flag unchanged", {31'd0, cop_out_full}, 32'd1);
    hread(4'h6, 0, rv); check("R7 out low", rv, 32'h0000_5678);
    check("R9 low read clears", {31'd0, cop_out_full}, 32'd0);
    hread(4'h4, 1, rv); check("R8 R9 payload kept", rv, 32'h1234_5678);
    cwrite(31'h0000_0011);
    hread(4'h4, 1, rv); check("R9 word read value", rv, 32'h8000_0011);
    check("R9 word read clears", {31'd0, cop_out_full}, 32'd0);
  endtask

  task automatic t_race_out();
    cwrite(31'h0AAA_0001);
    @(negedge clk);
    host_rd = 1; host_addr = 4'h6; host_size32 = 0;
    cop_out_wr = 1; cop_out_data = 31'h0555_0002;
    @(negedge clk);
    rv = host_rdata; idle();
    check("R10 old value read", rv, 32'h0000_0001);
    check("R10 flag stays", {31'd0, cop_out_full}, 32'd1);
    hread(4'h4, 0, rv); check("R10 new payload", rv, 32'h8555_0000);
  endtask

  task automatic t_window();
    hwrite(4'h0, 1, 32'h0000_0000);
    hwrite(4'h8, 1, 32'hFFFF_FFFF);
    hwrite(4'h1, 0, 32'hFFFF_FFFF);
    hread(4'h0, 1, rv); check("R12 no stray write", rv, 32'h0000_0000);
    hread(4'hC, 1, rv); check("R12 outside reads zero", rv, 32'h0000_0000);
    hread(4'h7, 0, rv); check("R12 misaligned reads zero", rv, 32'h0000_0000);
    check("R12 misaligned keeps flag", {31'd0, cop_out_full}, 32'd1);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_halves();
    t_word();
    t_accept();
    t_race_in();
    t_outbound();
    t_race_out();
    t_window();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule